// File: doc/BRIEF.md
# Discharge-Path Protection Controller

This block holds the digital decision logic on the discharge side of a two-cell battery protector. Comparators outside the block already turn the analog conditions into flags: an under-voltage flag per cell, an over-current flag and a short-circuit flag for the load pin, a flag that the load pin has been pulled down to the standby-return level, and the overcharge-trip state of the charge-side controller. A slow millisecond tick paces every delay. Each delay is a number of ticks that a flag must stay asserted without a break.

From these inputs the block drives four registered outputs. The first is the enable for the external discharge switch. The second selects a pull-up from the load pin to the supply, and the third selects a pull-down to ground. The fourth marks the low-power standby state. A deep discharge trip raises the pull-up and, in the usual case, enters standby. Standby is left only when a connected charger pulls the load pin down. A current fault raises the pull-down and recovers once the load flags clear. Fixed priority rules settle the cases where faults overlap. A test input shortens every delay so that production test runs quickly.

Top module: `dsg_guard_ctrl`

## Requirements
- R1: When either bit of `cell_uv` stays high for OD_DET_MS ticks (default 100) and `chg_trip` is low, the outputs become `dsg_en`=0, `pull_up`=1, `pull_dn`=0, `standby`=1.
- R2: While `standby` is 1, the block ignores the cell flags and keeps `dsg_en` low. Standby is left only in the cycle after `chg_low` is sampled high.
- R3: Once standby has been left, `dsg_en` returns to 1 and `pull_up` returns to 0 after both cell flags have stayed low for OD_RET_MS ticks (default 1).
- R4: An `oc_flag` held for OC_DET_MS ticks (default 20) gives `dsg_en`=0 and `pull_dn`=1. Standby stays 0.
- R5: An `sc_flag` held for SC_DET_MS ticks (default 1) gives the same outputs as R4.
- R6: After a current trip, `dsg_en` returns to 1 and `pull_dn` returns to 0 once `oc_flag` and `sc_flag` have both been low for CUR_RET_MS ticks (default 1).
- R7: While `chg_trip` is 1, `oc_flag` cannot cause a trip however long it is held, but `sc_flag` still trips as in R5.
- R8: An under-voltage trip taken while `chg_trip` is 1 sets `pull_up` but leaves `standby` at 0. Recovery then follows R3 and does not need `chg_low`.
- R9: An under-voltage trip taken while a current trip is held clears the current trip. `pull_dn` falls, `pull_up` rises and standby is entered. No current fault is detected while the under-voltage trip is held.
- R10: With `test_mode` high, every delay becomes max(1, delay >> TEST_SHIFT) ticks (default shift 4, so 100 becomes 6 and 20 becomes 1).
- R11: `pull_up` and `pull_dn` are never 1 together. `dsg_en` is 1 exactly when both pull selects are 0.
- R12: A detect count restarts from zero whenever its flag drops before the delay expires.
- R13: Synchronous reset gives `dsg_en`=1, `pull_up`=0, `pull_dn`=0, `standby`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond that paces all delays |
| test_mode | input | 1 | Shortens every counted delay |
| cell_uv | input | NCELL | Per-cell under-voltage flags |
| oc_flag | input | 1 | Load pin above the over-current level |
| sc_flag | input | 1 | Load pin above the short-circuit level |
| chg_low | input | 1 | Load pin at or below the standby-return level |
| chg_trip | input | 1 | Overcharge trip active in the charge-side controller |
| dsg_en | output | 1 | Discharge switch enable |
| pull_up | output | 1 | Select the load-pin pull-up to the supply |
| pull_dn | output | 1 | Select the load-pin pull-down to ground |
| standby | output | 1 | Low-power standby state |

## Verification
Directed sequences hold each fault flag for exactly one tick fewer than its delay and then for the full delay. This shows whether an off-by-one count or a missed restart (R12) occurs. Overlap cases set an overcharge trip or a current trip before an under-voltage trip. This separates the standby decision from the choice of pull select, and it shows whether the short-circuit path really bypasses the overcharge suppression. The test-mode pass repeats the under-voltage and over-current trips with the shortened limits. A long random run with sparse ticks then checks the invariants between the outputs on every cycle.

// File: rtl/dsg_guard_pkg.sv
package dsg_guard_pkg;

  localparam int unsigned NCNT       = 5;
  localparam int unsigned IX_OD_DET  = 0;
  localparam int unsigned IX_OD_RET  = 1;
  localparam int unsigned IX_OC_DET  = 2;
  localparam int unsigned IX_SC_DET  = 3;
  localparam int unsigned IX_CUR_RET = 4;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned shorten(input int unsigned lim, input int unsigned sh);
    int unsigned r;
    r = lim >> sh;
    return (r == 0) ? 1 : r;
  endfunction

endpackage

// File: rtl/dsg_guard_dly.sv
module dsg_guard_dly #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cond,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !cond) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q < limit)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = cond && (cnt_q >= limit);

  p_restart_r12: assert property (@(posedge clk) disable iff (rst)
    !cond |=> (cnt_q == '0));

  p_hold_without_tick_r12: assert property (@(posedge clk) disable iff (rst)
    (cond && !tick && $past(cond)) |=> $stable(cnt_q));

endmodule

// File: rtl/dsg_guard_out.sv
module dsg_guard_out (
  input  logic clk,
  input  logic rst,
  input  logic od_n,
  input  logic cur_n,
  input  logic st_n,
  output logic dsg_en,
  output logic pull_up,
  output logic pull_dn,
  output logic standby
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dsg_en  <= 1'b1;
      pull_up <= 1'b0;
      pull_dn <= 1'b0;
      standby <= 1'b0;
    end else begin
      dsg_en  <= !od_n && !cur_n;
      pull_up <= od_n;
      pull_dn <= cur_n && !od_n;
      standby <= st_n && od_n;
    end
  end

  p_pull_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(pull_up && pull_dn));

  p_enable_vs_pulls_r11: assert property (@(posedge clk) disable iff (rst)
    dsg_en == !(pull_up || pull_dn));

  p_standby_pullup_r1: assert property (@(posedge clk) disable iff (rst)
    standby |-> (pull_up && !dsg_en));

endmodule

// File: rtl/dsg_guard_ctrl.sv
module dsg_guard_ctrl #(
  parameter int unsigned NCELL      = 2,
  parameter int unsigned OD_DET_MS  = 100,
  parameter int unsigned OD_RET_MS  = 1,
  parameter int unsigned OC_DET_MS  = 20,
  parameter int unsigned SC_DET_MS  = 1,
  parameter int unsigned CUR_RET_MS = 1,
  parameter int unsigned TEST_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic             test_mode,
  input  logic [NCELL-1:0] cell_uv,
  input  logic             oc_flag,
  input  logic             sc_flag,
  input  logic             chg_low,
  input  logic             chg_trip,
  output logic             dsg_en,
  output logic             pull_up,
  output logic             pull_dn,
  output logic             standby
);
  import dsg_guard_pkg::*;

  localparam int unsigned LIM_N [NCNT] =
    '{OD_DET_MS, OD_RET_MS, OC_DET_MS, SC_DET_MS, CUR_RET_MS};
  localparam int unsigned LMAX =
    umax(umax(umax(OD_DET_MS, OD_RET_MS), umax(OC_DET_MS, SC_DET_MS)), CUR_RET_MS);
  localparam int unsigned CW = $clog2(LMAX + 1);

  logic          od_q, cur_q, st_q;
  logic          od_n, cur_n, st_n;
  logic          uv_any;
  logic [NCNT-1:0] cond;
  logic [NCNT-1:0] expd;
  logic [CW-1:0]   lim_w [NCNT];

  assign uv_any = |cell_uv;

  // detect and return conditions for each delay counter
  always_comb begin
    cond             = '0;
    cond[IX_OD_DET]  = uv_any && !od_q;
    cond[IX_OD_RET]  = od_q && !st_q && !uv_any;
    cond[IX_OC_DET]  = oc_flag && !chg_trip && !cur_q && !od_q;
    cond[IX_SC_DET]  = sc_flag && !cur_q && !od_q;
    cond[IX_CUR_RET] = cur_q && !oc_flag && !sc_flag && !od_q;
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    assign lim_w[g] = test_mode ? CW'(shorten(LIM_N[g], TEST_SHIFT)) : CW'(LIM_N[g]);
    dsg_guard_dly #(.CW(CW)) u_dly (
      .clk     (clk),
      .rst     (rst),
      .tick    (ms_tick),
      .cond    (cond[g]),
      .limit   (lim_w[g]),
      .expired (expd[g])
    );
  end

  // fault state priority: under-voltage trip last so it dominates
  always_comb begin
    od_n  = od_q;
    cur_n = cur_q;
    st_n  = st_q;
    if (st_q && chg_low) st_n = 1'b0;
    if (expd[IX_OD_RET]) od_n = 1'b0;
    if (expd[IX_CUR_RET]) cur_n = 1'b0;
    if (expd[IX_OC_DET] || expd[IX_SC_DET]) cur_n = 1'b1;
    if (expd[IX_OD_DET]) begin
      od_n  = 1'b1;
      cur_n = 1'b0;
      st_n  = !chg_trip;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      od_q  <= 1'b0;
      cur_q <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      od_q  <= od_n;
      cur_q <= cur_n;
      st_q  <= st_n;
    end
  end

  dsg_guard_out u_out (
    .clk     (clk),
    .rst     (rst),
    .od_n    (od_n),
    .cur_n   (cur_n),
    .st_n    (st_n),
    .dsg_en  (dsg_en),
    .pull_up (pull_up),
    .pull_dn (pull_dn),
    .standby (standby)
  );

  p_standby_exit_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(st_q) |-> $past(chg_low));

  p_no_standby_on_chg_trip_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q) |-> !$past(chg_trip));

  p_oc_masked_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(cur_q) && $past(chg_trip)) |-> $past(sc_flag));

  p_od_clears_cur_r9: assert property (@(posedge clk) disable iff (rst)
    od_q |-> !cur_q);

endmodule

// File: tb/dsg_guard_ctrl_bench.sv
module dsg_guard_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ms_tick = 1'b0;
  logic       test_mode = 1'b0;
  logic [1:0] cell_uv = 2'b00;
  logic       oc_flag = 1'b0;
  logic       sc_flag = 1'b0;
  logic       chg_low = 1'b0;
  logic       chg_trip = 1'b0;
  logic       dsg_en, pull_up, pull_dn, standby;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dsg_guard_ctrl u_dsg_guard_ctrl (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .test_mode(test_mode),
    .cell_uv(cell_uv), .oc_flag(oc_flag), .sc_flag(sc_flag),
    .chg_low(chg_low), .chg_trip(chg_trip),
    .dsg_en(dsg_en), .pull_up(pull_up), .pull_dn(pull_dn), .standby(standby)
  );

  // packed as {dsg_en, pull_up, pull_dn, standby}
  function automatic logic [3:0] vec(input bit de, input bit pu, input bit pd, input bit sb);
    return {de, pu, pd, sb};
  endfunction

  function automatic bit legal(input logic [3:0] v);
    return !(v[2] && v[1]) && (v[3] == !(v[2] || v[1])) && (!v[0] || (v[2] && !v[3]));
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {dsg_en, pull_up, pull_dn, standby};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pulse_chg_low();
    @(negedge clk) chg_low = 1'b1;
    @(negedge clk) chg_low = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R13 reset", vec(1, 0, 0, 0));

    // R12 then R1: interrupted count restarts
    cell_uv = 2'b01; tick(99);
    cell_uv = 2'b00; @(negedge clk); @(negedge clk);
    cell_uv = 2'b10; tick(99);
    check("R12 restart after drop", vec(1, 0, 0, 0));
    tick(1);
    check("R1 under-voltage trip", vec(0, 1, 0, 1));

    // R2: standby ignores recovered cells until chg_low
    cell_uv = 2'b00; tick(5);
    check("R2 standby holds", vec(0, 1, 0, 1));
    pulse_chg_low();
    check("R2 standby left on chg_low", vec(0, 1, 0, 0));
    tick(1);
    check("R3 return after delay", vec(1, 0, 0, 0));

    // R4 / R6 over-current
    oc_flag = 1'b1; tick(19);
    check("R4 before delay", vec(1, 0, 0, 0));
    tick(1);
    check("R4 over-current trip", vec(0, 0, 1, 0));
    oc_flag = 1'b0; @(negedge clk); @(negedge clk);
    check("R6 held until tick", vec(0, 0, 1, 0));
    tick(1);
    check("R6 current recovery", vec(1, 0, 0, 0));

    // R5 short-circuit
    sc_flag = 1'b1; tick(1);
    check("R5 short trip", vec(0, 0, 1, 0));
    sc_flag = 1'b0; tick(1);
    check("R6 short recovery", vec(1, 0, 0, 0));

    // R7 overcharge masks over-current only
    chg_trip = 1'b1; oc_flag = 1'b1; tick(30);
    check("R7 over-current masked", vec(1, 0, 0, 0));
    sc_flag = 1'b1; tick(1);
    check("R7 short still trips", vec(0, 0, 1, 0));
    oc_flag = 1'b0; sc_flag = 1'b0; tick(1);
    check("R7 recovery", vec(1, 0, 0, 0));

    // R8 under-voltage during overcharge trip: no standby
    cell_uv = 2'b11; tick(100);
    check("R8 pull-up without standby", vec(0, 1, 0, 0));
    cell_uv = 2'b00; tick(1);
    check("R8 return without chg_low", vec(1, 0, 0, 0));
    chg_trip = 1'b0;

    // R9 under-voltage overrides a held current trip
    oc_flag = 1'b1; tick(20);
    check("R9 current trip first", vec(0, 0, 1, 0));
    cell_uv = 2'b01; tick(100);
    check("R9 pull-up replaces pull-down", vec(0, 1, 0, 1));
    oc_flag = 1'b0; cell_uv = 2'b00;
    pulse_chg_low();
    tick(1);
    check("R9 recovery path", vec(1, 0, 0, 0));

    // R10 shortened delays
    test_mode = 1'b1;
    cell_uv = 2'b10; tick(5);
    check("R10 uv before 6 ticks", vec(1, 0, 0, 0));
    tick(1);
    check("R10 uv trip at 6 ticks", vec(0, 1, 0, 1));
    cell_uv = 2'b00; pulse_chg_low(); tick(1);
    check("R10 uv return", vec(1, 0, 0, 0));
    oc_flag = 1'b1; tick(1);
    check("R10 oc trip at 1 tick", vec(0, 0, 1, 0));
    oc_flag = 1'b0; tick(1);
    check("R10 oc return", vec(1, 0, 0, 0));

    // R11 random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      ms_tick   = ($urandom % 4) == 0;
      test_mode = ($urandom % 8) == 0;
      cell_uv   = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
      oc_flag   = ($urandom % 3) == 0;
      sc_flag   = ($urandom % 10) == 0;
      chg_low   = ($urandom % 20) == 0;
      chg_trip  = ($urandom % 5) == 0;
      checks++;
      if (!legal({dsg_en, pull_up, pull_dn, standby})) begin
        failures++;
        $display("FAIL R11 actual=%b expected=legal output combination",
                 {dsg_en, pull_up, pull_dn, standby});
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule